// File: doc/BRIEF.md
# Fuse Shadow-Read Sequencer

This block sits between a one-time-programmable fuse macro and the logic that needs the fuse contents. It stays idle with the macro powered down until the first field query arrives. It then unlocks the macro with a fixed key and powers it up. It walks the macro's control pins through the read ritual one row at a time and copies each row into a shadow register. Finally it powers the macro down and locks it again. This happens once per reset. Every later query is served from the shadow registers, and the macro is not touched again.

A query names two row indices and an inclusive bit range from high to low. The two rows are stored as a redundant pair, so the block ORs them together. It then shifts the merged word right by the low index and keeps the number of bits the range spans. A query whose indices fall outside the array returns zero and raises an error flag instead. All timing of the macro is counted in clock cycles. The count comes from the clock period in nanoseconds, rounded up.

Top module: `fuse_shadow_reader`

## Requirements
- R1: Out of reset, the outputs take these values. Power-down `fusePd` is 1 and chip select `fuseCsb` (active low) is 1. Program select `fusePs`, program-enable-bar `fuseProgEnN`, `fuseLoad` and `fuseStrobe` are 0. `fuseKey` is 0. `qReady` and `rValid` are 0.
- R2: The macro stays powered down until `qValid` is first seen high. `fuseKey` carries 16'h9DC4 whenever `fusePd` is 0, and `fusePs` stays 0 throughout the read.
- R3: `fuseCsb` falls no sooner than ceil(800 ns / period) cycles after `fusePd` falls.
- R4: The three control steps come in this order: `fuseCsb` falls first, then `fuseProgEnN` rises, then `fuseLoad` rises. All three happen before the first strobe.
- R5: There is one strobe pulse per row. The pulses visit rows 0 to 7 in ascending order on `fuseRow`, and `fuseRow` is stable while the strobe is high. Each pulse is high for at least ceil(100 ns / period) cycles. The data is captured at least ceil(50 ns / period) cycles after the strobe falls. The strobe is high only while `fuseLoad` is 1, `fuseCsb` is 0 and `fusePd` is 0.
- R6: After the eighth row, `fuseCsb` rises. At least ceil(50 ns / period) cycles later `fusePd` rises, and after that `fuseKey` returns to 0.
- R7: The read runs once per reset. Later queries cause no further power-up and no further strobe.
- R8: `qReady` is low until the read has completed. A query is accepted on a clock edge where `qValid` and `qReady` are both high. Exactly one cycle later `rValid` is high for one cycle per accepted query, and `rValid` is low at all other times.
- R9: A query is valid when all of these hold: `qHigh` < 32, `qLow` <= `qHigh`, `qRow1` < 8 and `qRow2` < 8. A valid query returns (row[qRow1] | row[qRow2]) >> `qLow`, masked to `qHigh` - `qLow` + 1 bits, with `rErr` = 0.
- R10: A query that is not valid returns `rData` = 0 with `rErr` = 1.
- R11: The range `qHigh` = 31 with `qLow` = 0 returns the full 32-bit merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| qValid | input | 1 | Query request |
| qRow1 | input | 4 | First row index of the query |
| qRow2 | input | 4 | Second row index of the query |
| qHigh | input | 6 | Upper bit index of the field, inclusive |
| qLow | input | 6 | Lower bit index of the field, inclusive |
| qReady | output | 1 | Query can be accepted |
| rValid | output | 1 | Result strobe, one cycle per query |
| rData | output | 32 | Extracted field, right aligned |
| rErr | output | 1 | Query was malformed |
| fuseKey | output | 16 | Unlock key presented to the macro |
| fusePd | output | 1 | Macro power-down |
| fusePs | output | 1 | Macro program select |
| fuseCsb | output | 1 | Macro chip select, active low |
| fuseProgEnN | output | 1 | Macro program-enable-bar |
| fuseLoad | output | 1 | Macro load enable |
| fuseStrobe | output | 1 | Macro read strobe |
| fuseRow | output | 3 | Macro row address |
| fuseData | input | 32 | Macro read data |

## Verification
Some properties are checked by the assertions on every cycle:
- the key is present while the macro is powered;
- chip select, program enable and load come up in order;
- the strobe is gated and holds the row stable;
- the power-up wait, strobe width and power-down hold are counted against their minimums;
- a result appears only after an accepted handshake;
- an error result is always zero.

The bench's scenarios show the rest. A behavioural macro stub returns scrambled data unless the strobe and capture timing are honoured. Only the bench can show that the rows are actually captured in the right order, that the field arithmetic is right across ranges and row pairs, and that the sequence starts lazily and runs only once.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [3:0] {
    SEQ_IDLE,
    SEQ_UNLOCK,
    SEQ_PWRWAIT,
    SEQ_PGEN,
    SEQ_LOADON,
    SEQ_ROWSET,
    SEQ_STBON,
    SEQ_STBHI,
    SEQ_STBLO,
    SEQ_CAPT,
    SEQ_HOLD,
    SEQ_PDOWN,
    SEQ_READY
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic accept;
  } ctrlStrobes_t;

  function automatic int nsToCycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int          ROWS          = 8,
  parameter int          CLK_PERIOD_NS = 4,
  parameter int          PWR_NS        = 800,
  parameter int          STB_HI_NS     = 100,
  parameter int          STB_LO_NS     = 50,
  parameter int          HOLD_NS       = 50,
  parameter int          KEY_W         = 16,
  parameter logic [15:0] UNLOCK_KEY    = 16'h9DC4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      qValid,
  output logic                      qReady,
  output ctrlStrobes_t              strobes,
  output logic [$clog2(ROWS)-1:0]   rowSel,
  output logic [KEY_W-1:0]          fuseKey,
  output logic                      fusePd,
  output logic                      fusePs,
  output logic                      fuseCsb,
  output logic                      fuseProgEnN,
  output logic                      fuseLoad,
  output logic                      fuseStrobe
);

  localparam int SEL_W    = $clog2(ROWS);
  localparam int PWR_CYC  = nsToCycles(PWR_NS, CLK_PERIOD_NS);
  localparam int HI_CYC   = nsToCycles(STB_HI_NS, CLK_PERIOD_NS);
  localparam int LO_CYC   = nsToCycles(STB_LO_NS, CLK_PERIOD_NS);
  localparam int HOLD_CYC = nsToCycles(HOLD_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC  = maxOf3(PWR_CYC, maxOf3(HI_CYC, LO_CYC, 1), HOLD_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  seqState_t        state;
  logic [CNT_W-1:0] waitCnt;
  logic [SEL_W-1:0] rowIdx;

  assign qReady          = (state == SEQ_READY);
  assign strobes.accept  = qValid && (state == SEQ_READY);
  assign strobes.capture = (state == SEQ_CAPT);
  assign rowSel          = rowIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= SEQ_IDLE;
      waitCnt     <= '0;
      rowIdx      <= '0;
      fuseKey     <= '0;
      fusePd      <= 1'b1;
      fusePs      <= 1'b0;
      fuseCsb     <= 1'b1;
      fuseProgEnN <= 1'b0;
      fuseLoad    <= 1'b0;
      fuseStrobe  <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (qValid) begin
            fuseKey <= KEY_W'(UNLOCK_KEY);
            state   <= SEQ_UNLOCK;
          end
        end
        SEQ_UNLOCK: begin
          fusePd  <= 1'b0;
          fusePs  <= 1'b0;
          waitCnt <= '0;
          state   <= SEQ_PWRWAIT;
        end
        SEQ_PWRWAIT: begin
          if (waitCnt == CNT_W'(PWR_CYC - 1)) begin
            fuseCsb <= 1'b0;
            state   <= SEQ_PGEN;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        SEQ_PGEN: begin
          fuseProgEnN <= 1'b1;
          state       <= SEQ_LOADON;
        end
        SEQ_LOADON: begin
          fuseLoad <= 1'b1;
          rowIdx   <= '0;
          state    <= SEQ_ROWSET;
        end
        SEQ_ROWSET: begin
          state <= SEQ_STBON;
        end
        SEQ_STBON: begin
          fuseStrobe <= 1'b1;
          waitCnt    <= '0;
          state      <= SEQ_STBHI;
        end
        SEQ_STBHI: begin
          if (waitCnt == CNT_W'(HI_CYC - 1)) begin
            fuseStrobe <= 1'b0;
            waitCnt    <= '0;
            state      <= SEQ_STBLO;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        SEQ_STBLO: begin
          if (waitCnt == CNT_W'(LO_CYC - 1)) begin
            state <= SEQ_CAPT;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        SEQ_CAPT: begin
          if (rowIdx == SEL_W'(ROWS - 1)) begin
            fuseCsb <= 1'b1;
            waitCnt <= '0;
            state   <= SEQ_HOLD;
          end else begin
            rowIdx <= rowIdx + 1'b1;
            state  <= SEQ_ROWSET;
          end
        end
        SEQ_HOLD: begin
          if (waitCnt == CNT_W'(HOLD_CYC - 1)) begin
            fusePd <= 1'b1;
            state  <= SEQ_PDOWN;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        SEQ_PDOWN: begin
          fuseKey <= '0;
          state   <= SEQ_READY;
        end
        SEQ_READY: begin
          state <= SEQ_READY;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int ROW_W     = 32,
  parameter int ROW_IDX_W = 4,
  parameter int BIT_IDX_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic [$clog2(ROWS)-1:0] rowSel,
  input  logic [ROW_W-1:0]        fuseData,
  input  logic [ROW_IDX_W-1:0]    qRow1,
  input  logic [ROW_IDX_W-1:0]    qRow2,
  input  logic [BIT_IDX_W-1:0]    qHigh,
  input  logic [BIT_IDX_W-1:0]    qLow,
  output logic                    rValid,
  output logic [ROW_W-1:0]        rData,
  output logic                    rErr
);

  localparam int SEL_W = $clog2(ROWS);

  logic [ROW_W-1:0] rowWords [ROWS];

  // one shadow register per fuse row, loaded only on its own capture slot
  for (genvar g = 0; g < ROWS; g++) begin : gShadow
    logic [ROW_W-1:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        word <= '0;
      end else if (strobes.capture && (rowSel == SEL_W'(g))) begin
        word <= fuseData;
      end
    end
    assign rowWords[g] = word;
  end

  logic                 highOk, lowOk, row1Ok, row2Ok, queryOk;
  logic [ROW_W-1:0]     merged, shifted, fieldMask, fieldVal;
  logic [BIT_IDX_W-1:0] span;
  logic [BIT_IDX_W:0]   fieldWidth;

  always_comb begin
    highOk  = int'(qHigh) < ROW_W;
    lowOk   = qLow <= qHigh;
    row1Ok  = int'(qRow1) < ROWS;
    row2Ok  = int'(qRow2) < ROWS;
    queryOk = highOk && lowOk && row1Ok && row2Ok;

    merged     = rowWords[qRow1[SEL_W-1:0]] | rowWords[qRow2[SEL_W-1:0]];
    shifted    = merged >> qLow;
    span       = qHigh - qLow;
    fieldWidth = {1'b0, span} + (BIT_IDX_W + 1)'(1);
    // a shift by the full word width clears everything, so the inverse is all ones
    fieldMask  = ~({ROW_W{1'b1}} << fieldWidth);
    fieldVal   = queryOk ? (shifted & fieldMask) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rValid <= 1'b0;
      rData  <= '0;
      rErr   <= 1'b0;
    end else begin
      rValid <= strobes.accept;
      if (strobes.accept) begin
        rData <= fieldVal;
        rErr  <= !queryOk;
      end
    end
  end

endmodule

// File: rtl/fuse_shadow_reader.sv
module fuse_shadow_reader
  import fsr_pkg::*;
#(
  parameter int          ROWS          = 8,
  parameter int          ROW_W         = 32,
  parameter int          ROW_IDX_W     = 4,
  parameter int          BIT_IDX_W     = 6,
  parameter int          CLK_PERIOD_NS = 4,
  parameter int          PWR_NS        = 800,
  parameter int          STB_HI_NS     = 100,
  parameter int          STB_LO_NS     = 50,
  parameter int          HOLD_NS       = 50,
  parameter int          KEY_W         = 16,
  parameter logic [15:0] UNLOCK_KEY    = 16'h9DC4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    qValid,
  input  logic [ROW_IDX_W-1:0]    qRow1,
  input  logic [ROW_IDX_W-1:0]    qRow2,
  input  logic [BIT_IDX_W-1:0]    qHigh,
  input  logic [BIT_IDX_W-1:0]    qLow,
  output logic                    qReady,
  output logic                    rValid,
  output logic [ROW_W-1:0]        rData,
  output logic                    rErr,
  output logic [KEY_W-1:0]        fuseKey,
  output logic                    fusePd,
  output logic                    fusePs,
  output logic                    fuseCsb,
  output logic                    fuseProgEnN,
  output logic                    fuseLoad,
  output logic                    fuseStrobe,
  output logic [$clog2(ROWS)-1:0] fuseRow,
  input  logic [ROW_W-1:0]        fuseData
);

  ctrlStrobes_t            strobes;
  logic [$clog2(ROWS)-1:0] rowSel;

  fsr_ctrl #(
    .ROWS(ROWS), .CLK_PERIOD_NS(CLK_PERIOD_NS), .PWR_NS(PWR_NS),
    .STB_HI_NS(STB_HI_NS), .STB_LO_NS(STB_LO_NS), .HOLD_NS(HOLD_NS),
    .KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .qValid(qValid), .qReady(qReady),
    .strobes(strobes), .rowSel(rowSel), .fuseKey(fuseKey),
    .fusePd(fusePd), .fusePs(fusePs), .fuseCsb(fuseCsb),
    .fuseProgEnN(fuseProgEnN), .fuseLoad(fuseLoad), .fuseStrobe(fuseStrobe)
  );

  assign fuseRow = rowSel;

  fsr_datapath #(
    .ROWS(ROWS), .ROW_W(ROW_W), .ROW_IDX_W(ROW_IDX_W), .BIT_IDX_W(BIT_IDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rowSel(rowSel),
    .fuseData(fuseData), .qRow1(qRow1), .qRow2(qRow2), .qHigh(qHigh),
    .qLow(qLow), .rValid(rValid), .rData(rData), .rErr(rErr)
  );

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
#(
  parameter int          ROWS          = 8,
  parameter int          ROW_W         = 32,
  parameter int          CLK_PERIOD_NS = 4,
  parameter int          PWR_NS        = 800,
  parameter int          STB_HI_NS     = 100,
  parameter int          HOLD_NS       = 50,
  parameter int          KEY_W         = 16,
  parameter logic [15:0] UNLOCK_KEY    = 16'h9DC4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    qValid,
  input logic                    qReady,
  input logic                    rValid,
  input logic [ROW_W-1:0]        rData,
  input logic                    rErr,
  input logic [KEY_W-1:0]        fuseKey,
  input logic                    fusePd,
  input logic                    fuseCsb,
  input logic                    fuseProgEnN,
  input logic                    fuseLoad,
  input logic                    fuseStrobe,
  input logic [$clog2(ROWS)-1:0] fuseRow
);

  localparam int PWR_CYC  = nsToCycles(PWR_NS, CLK_PERIOD_NS);
  localparam int HI_CYC   = nsToCycles(STB_HI_NS, CLK_PERIOD_NS);
  localparam int HOLD_CYC = nsToCycles(HOLD_NS, CLK_PERIOD_NS);

  int pwrCnt, hiCnt, holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCnt  <= 0;
      hiCnt   <= 0;
      holdCnt <= 0;
    end else begin
      pwrCnt  <= (!fusePd && fuseCsb) ? pwrCnt + 1 : 0;
      hiCnt   <= fuseStrobe ? hiCnt + 1 : 0;
      holdCnt <= !fuseCsb ? 0 : (!fusePd ? holdCnt + 1 : holdCnt);
    end
  end

  assert_key_powered_R2: assert property (@(posedge clk) disable iff (!rstN)
    !fusePd |-> fuseKey == KEY_W'(UNLOCK_KEY));

  assert_power_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(fuseCsb) && !fusePd) |-> pwrCnt >= PWR_CYC);

  assert_pgen_after_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fuseProgEnN) |-> (!fuseCsb && !fuseLoad));

  assert_load_after_pgen_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fuseLoad) |-> (fuseProgEnN && !fuseCsb));

  assert_strobe_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    fuseStrobe |-> (fuseLoad && !fuseCsb && !fusePd));

  assert_row_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fuseStrobe && $past(fuseStrobe)) |-> $stable(fuseRow));

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fuseStrobe) |-> hiCnt >= HI_CYC);

  assert_hold_before_pd_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fusePd) |-> (fuseCsb && holdCnt >= HOLD_CYC));

  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    qReady |-> (fusePd && fuseCsb && !fuseStrobe));

  assert_result_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> $past(qValid && qReady));

  assert_error_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rErr) |-> rData == '0);

endmodule

bind fuse_shadow_reader fsr_checker #(
  .ROWS(ROWS), .ROW_W(ROW_W), .CLK_PERIOD_NS(CLK_PERIOD_NS), .PWR_NS(PWR_NS),
  .STB_HI_NS(STB_HI_NS), .HOLD_NS(HOLD_NS), .KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY)
) uChecker (.*);

// File: tb/tb_fuse_shadow_reader.sv
`timescale 1ns/1ps
module tb_fuse_shadow_reader;

  localparam int PERIOD   = 4;
  localparam int PWR_CYC  = (800 + PERIOD - 1) / PERIOD;
  localparam int HI_CYC   = (100 + PERIOD - 1) / PERIOD;
  localparam int LO_CYC   = (50 + PERIOD - 1) / PERIOD;
  localparam int HOLD_CYC = (50 + PERIOD - 1) / PERIOD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        qValid = 1'b0;
  logic [3:0]  qRow1 = '0, qRow2 = '0;
  logic [5:0]  qHigh = '0, qLow = '0;
  logic        qReady, rValid, rErr;
  logic [31:0] rData;
  logic [15:0] fuseKey;
  logic        fusePd, fusePs, fuseCsb, fuseProgEnN, fuseLoad, fuseStrobe;
  logic [2:0]  fuseRow;
  logic [31:0] fuseData;

  always #(PERIOD / 2.0) clk = ~clk;

  fuse_shadow_reader dut (
    .clk(clk), .rstN(rstN), .qValid(qValid), .qRow1(qRow1), .qRow2(qRow2),
    .qHigh(qHigh), .qLow(qLow), .qReady(qReady), .rValid(rValid),
    .rData(rData), .rErr(rErr), .fuseKey(fuseKey), .fusePd(fusePd),
    .fusePs(fusePs), .fuseCsb(fuseCsb), .fuseProgEnN(fuseProgEnN),
    .fuseLoad(fuseLoad), .fuseStrobe(fuseStrobe), .fuseRow(fuseRow),
    .fuseData(fuseData)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural macro stub: fuse contents and read timing
  logic [31:0] fuseMem [8];
  logic [31:0] stubLatch = 32'h0;
  bit          stubOk = 0;
  int          lowCnt = 0, hiCnt = 0;
  assign fuseData = (stubOk && lowCnt >= LO_CYC) ? stubLatch : 32'hA5A5_A5A5;

  function automatic void expectQuery(input int r1, input int r2, input int h, input int l,
                                      output logic [31:0] d, output logic e);
    logic [31:0] m;
    d = '0;
    if (h < 32 && l <= h && r1 < 8 && r2 < 8) begin
      m = fuseMem[r1] | fuseMem[r2];
      for (int b = l; b <= h; b++) d[b - l] = m[b];
      e = 1'b0;
    end else begin
      e = 1'b1;
    end
  endfunction

  // monitor state
  bit          started = 0, queryIssued = 0;
  string       curTag = "";
  bit          expPend = 0;
  logic [31:0] expData;
  logic        expErr;
  string       expTag;
  logic        pPd = 1, pCsb = 1, pPgen = 0, pLoad = 0, pStb = 0;
  logic [15:0] pKey = 0;
  int          pwrCnt = 0, holdCnt = 0, strobeRises = 0, pdFalls = 0;
  int          nextRow = 0;
  logic [2:0]  riseRow = 0;

  always @(negedge clk) begin
    if (started) begin
      // result channel, compared on every clock
      if (expPend)
        chk(rValid === 1'b1 && rData === expData && rErr === expErr,
            {expTag, " result"}, {rValid, rErr, rData}, {1'b1, expErr, expData});
      else
        chk(rValid === 1'b0, "R8 no result without accept", rValid, 0);

      if (qValid && qReady) begin
        expectQuery(int'(qRow1), int'(qRow2), int'(qHigh), int'(qLow), expData, expErr);
        expTag  = curTag;
        expPend = 1;
      end else begin
        expPend = 0;
      end

      // power-up
      if (pPd && !fusePd) begin
        pdFalls++;
        chk(fuseKey == 16'h9DC4 && !fusePs && queryIssued, "R2 key before power-up",
            fuseKey, 16'h9DC4);
      end
      if (!fusePd && fuseCsb) pwrCnt++;
      else if (fusePd) pwrCnt = 0;

      if (pCsb && !fuseCsb) begin
        chk(pwrCnt >= PWR_CYC, "R3 power-up wait", pwrCnt, PWR_CYC);
        chk(!qReady, "R8 ready low during read", qReady, 0);
      end
      if (!pPgen && fuseProgEnN)
        chk(!fuseCsb && !fuseLoad, "R4 program-enable after chip select",
            {fuseCsb, fuseLoad}, 0);
      if (!pLoad && fuseLoad)
        chk(fuseProgEnN && !fuseCsb, "R4 load after program-enable",
            {fuseProgEnN, fuseCsb}, 2'b10);

      // strobes
      if (!pStb && fuseStrobe) begin
        chk(fuseLoad && int'(fuseRow) == nextRow && (strobeRises == 0 || lowCnt >= LO_CYC),
            "R5 strobe rise row/order", fuseRow, nextRow);
        riseRow = fuseRow;
        strobeRises++;
        hiCnt = 1;
      end else if (fuseStrobe) begin
        hiCnt++;
      end
      if (pStb && !fuseStrobe) begin
        chk(hiCnt >= HI_CYC && fuseRow == riseRow, "R5 strobe width and row hold",
            hiCnt, HI_CYC);
        stubOk    = (hiCnt >= HI_CYC) && !fuseCsb && fuseLoad && fuseProgEnN &&
                    !fusePd && fuseKey == 16'h9DC4;
        stubLatch = fuseMem[fuseRow];
        lowCnt    = 1;
        nextRow   = int'(fuseRow) + 1;
      end else if (!fuseStrobe) begin
        lowCnt++;
      end

      // power-down
      if (!pCsb && fuseCsb)
        chk(strobeRises == 8 && !fusePd, "R6 chip select release after last row",
            strobeRises, 8);
      if (!fuseCsb) holdCnt = 0;
      else if (!fusePd) holdCnt++;
      if (!pPd && fusePd)
        chk(fuseCsb && holdCnt >= HOLD_CYC, "R6 hold before power-down", holdCnt, HOLD_CYC);
      if (pKey != 0 && fuseKey == 0)
        chk(fusePd, "R6 key cleared after power-down", fusePd, 1);
    end
    pPd = fusePd; pCsb = fuseCsb; pPgen = fuseProgEnN; pLoad = fuseLoad;
    pStb = fuseStrobe; pKey = fuseKey;
  end

  task automatic query(input int r1, input int r2, input int h, input int l, input string tag);
    @(posedge clk); #1;
    qRow1 = 4'(r1); qRow2 = 4'(r2); qHigh = 6'(h); qLow = 6'(l);
    curTag = tag;
    qValid = 1'b1;
    queryIssued = 1;
    forever begin
      @(negedge clk);
      if (qReady) break;
    end
    @(posedge clk); #1;
    qValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    fuseMem[0] = 32'h1234_0078; fuseMem[1] = 32'h0000_5600;
    fuseMem[2] = 32'h9ABC_0000; fuseMem[3] = 32'h0000_DEF0;
    fuseMem[4] = 32'h8000_0001; fuseMem[5] = 32'h0F0F_0F0F;
    fuseMem[6] = 32'hF0F0_F0F0; fuseMem[7] = 32'h0000_0000;

    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(fusePd === 1'b1 && fuseCsb === 1'b1, "R1 power-down and chip select idle",
        {fusePd, fuseCsb}, 2'b11);
    chk(fusePs === 1'b0 && fuseProgEnN === 1'b0 && fuseLoad === 1'b0 && fuseStrobe === 1'b0,
        "R1 control pins low", {fusePs, fuseProgEnN, fuseLoad, fuseStrobe}, 0);
    chk(fuseKey === 16'h0, "R1 key cleared", fuseKey, 0);
    chk(qReady === 1'b0 && rValid === 1'b0, "R1 handshake idle", {qReady, rValid}, 0);
    started = 1;

    repeat (30) @(negedge clk);
    chk(fusePd === 1'b1 && strobeRises == 0, "R2 macro idle until first query", fusePd, 1);

    query(0, 1, 31, 0, "R11 full range");
    chk(strobeRises == 8 && pdFalls == 1, "R7 one complete read", strobeRises, 8);
    query(2, 3, 15, 4, "R9 middle field");
    query(4, 4, 31, 31, "R9 top bit");
    query(5, 6, 7, 0, "R9 complementary rows");
    query(7, 7, 31, 0, "R9 empty row");
    query(0, 3, 31, 0, "R11 full range second pair");
    query(0, 1, 32, 0, "R10 high out of range");
    query(0, 1, 3, 5, "R10 low above high");
    query(8, 1, 7, 0, "R10 first row out of range");
    query(0, 15, 7, 0, "R10 second row out of range");
    query(15, 15, 63, 63, "R10 all fields maxed");
    query(6, 5, 27, 20, "R9 after error");
    query(1, 2, 0, 0, "R9 bottom bit");

    repeat (10) @(negedge clk);
    chk(strobeRises == 8 && pdFalls == 1, "R7 no second read", {pdFalls, strobeRises}, 8);
    chk(fusePd === 1'b1 && fuseCsb === 1'b1 && fuseKey === 16'h0,
        "R6 macro left locked and down", {fusePd, fuseCsb, fuseKey}, {1'b1, 1'b1, 16'h0});
    chk(qReady === 1'b1, "R8 ready after read", qReady, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired (R8 handshake hung) actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule